// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This controller sits beside the decode stage of a five-stage in-order pipeline. The stages are fetch, decode, execute, memory access and write-back. Each instruction is offered as it is latched into decode. The controller takes its source register numbers and read enables, its destination register and write enable, and whether it is a load or a branch. It keeps the destination information of the instruction in decode and of the last few slots issued to execute, with empty slots included. From this it works out how many bubble cycles the new instruction must wait, and it registers the answer so that the stall output is steady while the instruction sits in decode.

The number of bubbles comes from stage-position arithmetic. The stage where the producer's result becomes available, minus the stage where the consumer needs it, minus one, gives the required gap. Each slot already between producer and consumer reduces that gap. A static mode selects whether a forwarding network exists, and it is captured during reset. When a branch leaves decode, the controller squashes fetch for the branch's gap. The datapath and the operand multiplexers are outside the block.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: While and right after reset, `stall_o`, `squash_o` and `bubbles_o` are 0.
- R2: With forwarding off, a consumer accepted directly behind an ALU or load producer of one of its enabled sources gets 2 bubbles. `stall_o` is high for exactly that many cycles, starting the cycle after acceptance. During the stall `bubbles_o` shows the remaining count and falls by one each cycle.
- R3: With forwarding on, a consumer directly behind an ALU producer gets 0 bubbles and one directly behind a load producer gets 1 bubble.
- R4: A consumer gets no stall when none of its enabled sources matches a recent writing producer. Register 0 and producers with the write enable low never cause a stall.
- R5: Every slot between producer and consumer counts toward the gap, and this includes stall bubbles already inserted. The bubbles required are the class gap minus the slots in between, floored at 0.
- R6: When both sources depend on different producers, the stall is the larger of the two requirements, not their sum.
- R7: When a branch leaves decode, `squash_o` is high for exactly 3 cycles with forwarding off, or 1 cycle with it on. No instruction is accepted at the edge where the branch leaves or during the squash.
- R8: `fwd_en_i` is captured only while `rst_ni` is low. Changes to it after reset have no effect.
- R9: `stall_o` and `squash_o` are never high together.
- R10: An instruction offered while `stall_o` is high is ignored. Decode keeps the stalled instruction, and the ignored one never becomes a producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fwd_en_i | input | 1 | Forwarding present, captured during reset |
| in_valid_i | input | 1 | An instruction is offered to decode |
| rs1_i | input | REG_AW | First source register |
| rs1_en_i | input | 1 | First source is read |
| rs2_i | input | REG_AW | Second source register |
| rs2_en_i | input | 1 | Second source is read |
| rd_i | input | REG_AW | Destination register |
| rd_we_i | input | 1 | Destination is written |
| is_load_i | input | 1 | Instruction is a load |
| is_branch_i | input | 1 | Instruction is a branch |
| stall_o | output | 1 | Hold PC and decode, inject bubble into execute |
| squash_o | output | 1 | Discard fetched instruction after a branch |
| bubbles_o | output | CNT_W | Remaining stall or squash cycles |

## Verification
An offer is accepted at the rising edge that follows it. The registered stall decision and its count are visible in the cycle right after that edge. A branch's squash starts one cycle later, because the branch must first leave decode. The bench drives inputs and samples outputs on falling edges. Each stall or squash check begins at the first falling edge where the result is due, and it counts consecutive high cycles while comparing `bubbles_o` against the expected remaining count in each of them. Cases that test ignored input read the effect back through the stall that a later dependent instruction would have got.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int unsigned STG_IF = 1;
  localparam int unsigned STG_ID = 2;
  localparam int unsigned STG_EX = 3;
  localparam int unsigned STG_MA = 4;
  localparam int unsigned STG_WB = 5;

  function automatic int unsigned stage_gap(int unsigned avail, int unsigned need);
    return avail - need - 1;
  endfunction

  localparam int unsigned ALU_GAP_NF = stage_gap(STG_WB, STG_ID);
  localparam int unsigned LD_GAP_NF  = stage_gap(STG_WB, STG_ID);
  localparam int unsigned BR_GAP_NF  = stage_gap(STG_WB, STG_IF);
  localparam int unsigned ALU_GAP_FW = stage_gap(STG_EX, STG_ID);
  localparam int unsigned LD_GAP_FW  = stage_gap(STG_MA, STG_ID);
  localparam int unsigned BR_GAP_FW  = stage_gap(STG_EX, STG_IF);

  function automatic int unsigned data_gap(logic fwd, logic ld);
    if (fwd) return ld ? LD_GAP_FW : ALU_GAP_FW;
    return ld ? LD_GAP_NF : ALU_GAP_NF;
  endfunction
endpackage

// File: rtl/hsc_history.sv
module hsc_history #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_we_i,
  input  logic [REG_AW-1:0]            push_rd_i,
  input  logic                         push_ld_i,
  output logic [DEPTH-1:0]             we_o,
  output logic [DEPTH-1:0][REG_AW-1:0] rd_o,
  output logic [DEPTH-1:0]             ld_o
);
  // shifts every cycle; bubbles enter as non-writing slots
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          we_o[0] <= 1'b0;
          rd_o[0] <= '0;
          ld_o[0] <= 1'b0;
        end else begin
          we_o[0] <= push_we_i;
          rd_o[0] <= push_rd_i;
          ld_o[0] <= push_ld_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          we_o[i] <= 1'b0;
          rd_o[i] <= '0;
          ld_o[i] <= 1'b0;
        end else begin
          we_o[i] <= we_o[i-1];
          rd_o[i] <= rd_o[i-1];
          ld_o[i] <= ld_o[i-1];
        end
      end
    end
  end
endmodule

// File: rtl/hsc_dep_check.sv
module hsc_dep_check
  import hsc_pkg::*;
#(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned ENTRIES = 3,
  parameter int unsigned CNT_W   = 2
) (
  input  logic                           fwd_i,
  input  logic [1:0][REG_AW-1:0]         src_i,
  input  logic [1:0]                     src_en_i,
  input  logic [ENTRIES-1:0]             ent_we_i,
  input  logic [ENTRIES-1:0][REG_AW-1:0] ent_rd_i,
  input  logic [ENTRIES-1:0]             ent_ld_i,
  output logic [CNT_W-1:0]               need_o
);
  logic [1:0][ENTRIES-1:0][CNT_W-1:0] req;

  // entry e sits e slots ahead of the slot directly in front of the consumer
  for (genvar s = 0; s < 2; s++) begin : g_src
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic        hit;
      int unsigned gap;
      assign hit = src_en_i[s] && ent_we_i[e] && (src_i[s] != '0) &&
                   (src_i[s] == ent_rd_i[e]);
      assign gap = data_gap(fwd_i, ent_ld_i[e]);
      assign req[s][e] = (hit && gap > e) ? CNT_W'(gap - e) : '0;
    end
  end

  always_comb begin
    need_o = '0;
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < ENTRIES; e++)
        if (req[s][e] > need_o) need_o = req[s][e];
  end
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hsc_pkg::*;
#(
  parameter int unsigned REG_AW     = 5,
  parameter int unsigned HIST_DEPTH = 2,
  parameter int unsigned CNT_W      = $clog2(BR_GAP_NF + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic              in_valid_i,
  input  logic [REG_AW-1:0] rs1_i,
  input  logic              rs1_en_i,
  input  logic [REG_AW-1:0] rs2_i,
  input  logic              rs2_en_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic              rd_we_i,
  input  logic              is_load_i,
  input  logic              is_branch_i,
  output logic              stall_o,
  output logic              squash_o,
  output logic [CNT_W-1:0]  bubbles_o
);
  localparam int unsigned ENTRIES = HIST_DEPTH + 1;

  logic              fwd_q;
  logic              slot_v_q, slot_we_q, slot_ld_q, slot_br_q;
  logic [REG_AW-1:0] slot_rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sq_q;

  logic [HIST_DEPTH-1:0]             h_we, h_ld;
  logic [HIST_DEPTH-1:0][REG_AW-1:0] h_rd;
  logic [ENTRIES-1:0]                ent_we, ent_ld;
  logic [ENTRIES-1:0][REG_AW-1:0]    ent_rd;
  logic [CNT_W-1:0]                  need, br_gap;
  logic                              hold, leave, br_leave, accept;

  // mode captured on clock edges while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) fwd_q <= fwd_en_i;
  end

  assign hold     = (cnt_q != '0);
  assign leave    = !hold && slot_v_q;
  assign br_leave = leave && slot_br_q;
  assign accept   = !hold && !br_leave && in_valid_i;
  assign br_gap   = fwd_q ? CNT_W'(BR_GAP_FW) : CNT_W'(BR_GAP_NF);

  assign ent_we = {h_we, slot_v_q & slot_we_q};
  assign ent_rd = {h_rd, slot_rd_q};
  assign ent_ld = {h_ld, slot_ld_q};

  hsc_history #(.REG_AW(REG_AW), .DEPTH(HIST_DEPTH)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_we_i (leave && slot_we_q),
    .push_rd_i (slot_rd_q),
    .push_ld_i (slot_ld_q),
    .we_o      (h_we),
    .rd_o      (h_rd),
    .ld_o      (h_ld)
  );

  hsc_dep_check #(.REG_AW(REG_AW), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_dep (
    .fwd_i    (fwd_q),
    .src_i    ({rs2_i, rs1_i}),
    .src_en_i ({rs2_en_i, rs1_en_i}),
    .ent_we_i (ent_we),
    .ent_rd_i (ent_rd),
    .ent_ld_i (ent_ld),
    .need_o   (need)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q  <= 1'b0;
      slot_we_q <= 1'b0;
      slot_ld_q <= 1'b0;
      slot_br_q <= 1'b0;
      slot_rd_q <= '0;
      cnt_q     <= '0;
      sq_q      <= 1'b0;
    end else if (hold) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (br_leave) begin
      slot_v_q <= 1'b0;
      cnt_q    <= br_gap;
      sq_q     <= 1'b1;
    end else if (accept) begin
      slot_v_q  <= 1'b1;
      slot_we_q <= rd_we_i;
      slot_ld_q <= is_load_i;
      slot_br_q <= is_branch_i;
      slot_rd_q <= rd_i;
      cnt_q     <= need;
      sq_q      <= 1'b0;
    end else begin
      slot_v_q <= 1'b0;
    end
  end

  assign stall_o   = hold && !sq_q;
  assign squash_o  = hold && sq_q;
  assign bubbles_o = cnt_q;
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int unsigned CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stall_o,
  input logic             squash_o,
  input logic [CNT_W-1:0] bubbles_o,
  input logic             fwd_q,
  input logic             slot_v_q,
  input logic             slot_br_q
);
  AST_STALL_SQUASH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o && squash_o)); // R9

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o || squash_o) |=> (bubbles_o == $past(bubbles_o) - CNT_W'(1))); // R2

  AST_FWD_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_q |-> (bubbles_o <= CNT_W'(1))); // R3

  AST_SQUASH_AFTER_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(squash_o) |-> $past(slot_v_q && slot_br_q)); // R7

  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(fwd_q)); // R8
endmodule

bind hazard_stall_ctrl hsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stall_o   (stall_o),
  .squash_o  (squash_o),
  .bubbles_o (bubbles_o),
  .fwd_q     (fwd_q),
  .slot_v_q  (slot_v_q),
  .slot_br_q (slot_br_q)
);

// File: tb/hazard_stall_ctrl_test.sv
module hazard_stall_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fwd_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] rs1 = '0, rs2 = '0, rd = '0;
  logic       rs1_en = 1'b0, rs2_en = 1'b0, rd_we = 1'b0, is_ld = 1'b0, is_br = 1'b0;
  logic       stall, squash;
  logic [1:0] bubbles;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  hazard_stall_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .fwd_en_i(fwd_en), .in_valid_i(in_valid),
    .rs1_i(rs1), .rs1_en_i(rs1_en), .rs2_i(rs2), .rs2_en_i(rs2_en),
    .rd_i(rd), .rd_we_i(rd_we), .is_load_i(is_ld), .is_branch_i(is_br),
    .stall_o(stall), .squash_o(squash), .bubbles_o(bubbles)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int s1, input bit e1, input int s2, input bit e2,
                       input int d, input bit we, input bit ld, input bit br);
    in_valid = 1'b1;
    rs1 = 5'(s1); rs1_en = e1; rs2 = 5'(s2); rs2_en = e2;
    rd = 5'(d); rd_we = we; is_ld = ld; is_br = br;
  endtask

  // offer at a falling edge, accepted at next rising edge, return at following falling edge
  task automatic present(input int s1, input bit e1, input int s2, input bit e2,
                         input int d, input bit we, input bit ld, input bit br);
    for (int i = 0; i < 10 && (stall || squash); i++) @(negedge clk);
    drive(s1, e1, s2, e2, d, we, ld, br);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_stall(input int n, input string tag);
    int c = 0;
    check(bubbles == 2'(n), {tag, " bubble count"}, bubbles, n);
    while (stall && c < 8) begin
      check(bubbles == 2'(n - c), {tag, " countdown"}, bubbles, n - c);
      c++;
      @(negedge clk);
    end
    check(c == n, {tag, " stall cycles"}, c, n);
  endtask

  task automatic expect_squash(input int n, input string tag);
    int c = 0;
    check(!stall, {tag, " no stall during squash"}, stall, 0);
    while (squash && c < 8) begin
      c++;
      @(negedge clk);
    end
    check(c == n, {tag, " squash cycles"}, c, n);
  endtask

  task automatic flush();
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input bit fwd);
    @(negedge clk);
    rst_n = 1'b0;
    fwd_en = fwd;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!stall && !squash && bubbles == 0, "R1 outputs in reset", bubbles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall && !squash && bubbles == 0, "R1 outputs after reset", bubbles, 0);
  endtask

  task automatic t_alu_dep();
    flush();
    present(0, 0, 0, 0, 1, 1, 0, 0);
    expect_stall(0, "R4 producer alone");
    present(1, 1, 0, 0, 2, 1, 0, 0);
    expect_stall(2, "R2 alu dep");
    present(1, 1, 0, 0, 3, 1, 0, 0);
    expect_stall(0, "R5 bubbles count as distance");
  endtask

  task automatic t_load_dep();
    flush();
    present(0, 0, 0, 0, 2, 1, 1, 0);
    present(0, 0, 2, 1, 4, 1, 0, 0);
    expect_stall(2, "R2 load dep on rs2");
  endtask

  task automatic t_gap(input int exp, input string tag);
    flush();
    present(0, 0, 0, 0, 3, 1, 1, 0);
    present(10, 1, 0, 0, 11, 1, 0, 0);
    expect_stall(0, {tag, " filler"});
    present(3, 1, 0, 0, 12, 1, 0, 0);
    expect_stall(exp, tag);
  endtask

  task automatic t_indep();
    flush();
    present(0, 0, 0, 0, 4, 1, 0, 0);
    present(5, 1, 6, 1, 7, 1, 0, 0);
    expect_stall(0, "R4 independent");
    flush();
    present(0, 0, 0, 0, 0, 1, 0, 0);
    present(0, 1, 0, 1, 8, 1, 0, 0);
    expect_stall(0, "R4 register 0");
    flush();
    present(0, 0, 0, 0, 6, 0, 1, 0);
    present(6, 1, 0, 0, 8, 1, 0, 0);
    expect_stall(0, "R4 write disabled");
    flush();
    present(0, 0, 0, 0, 13, 1, 0, 0);
    present(13, 0, 13, 0, 8, 1, 0, 0);
    expect_stall(0, "R4 read disabled");
  endtask

  task automatic t_max();
    flush();
    present(0, 0, 0, 0, 1, 1, 0, 0);
    present(0, 0, 0, 0, 2, 1, 0, 0);
    present(1, 1, 2, 1, 3, 1, 0, 0);
    expect_stall(2, "R6 max of two sources");
    flush();
    present(0, 0, 0, 0, 2, 1, 1, 0);
    present(0, 0, 0, 0, 1, 1, 0, 0);
    present(2, 1, 1, 1, 3, 1, 0, 0);
    expect_stall(2, "R6 swapped sources");
  endtask

  task automatic t_hold();
    flush();
    present(0, 0, 0, 0, 1, 1, 0, 0);
    present(1, 1, 0, 0, 2, 0, 0, 0);
    drive(0, 0, 0, 0, 7, 1, 0, 0);
    expect_stall(2, "R10 stall with offer");
    present(7, 1, 0, 0, 8, 1, 0, 0);
    expect_stall(0, "R10 offer during stall ignored");
  endtask

  task automatic t_branch(input int n, input string tag);
    flush();
    present(0, 0, 0, 0, 0, 0, 0, 1);
    check(!stall && !squash, {tag, " branch in decode"}, squash, 0);
    drive(0, 0, 0, 0, 9, 1, 0, 0);
    @(negedge clk);
    expect_squash(n, tag);
    present(9, 1, 0, 0, 10, 1, 0, 0);
    expect_stall(0, {tag, " squashed offer ignored"});
  endtask

  task automatic t_fwd();
    flush();
    present(0, 0, 0, 0, 1, 1, 0, 0);
    present(1, 1, 0, 0, 2, 1, 0, 0);
    expect_stall(0, "R3 alu forwarded");
    flush();
    present(0, 0, 0, 0, 2, 1, 1, 0);
    present(0, 0, 2, 1, 3, 1, 0, 0);
    expect_stall(1, "R3 load forwarded");
  endtask

  task automatic t_mode_latch();
    fwd_en = 1'b0;
    flush();
    present(0, 0, 0, 0, 2, 1, 1, 0);
    present(2, 1, 0, 0, 3, 1, 0, 0);
    expect_stall(1, "R8 mode change ignored");
  endtask

  initial begin
    do_reset(1'b0);
    t_alu_dep();
    t_load_dep();
    t_gap(1, "R5 one filler no fwd");
    t_indep();
    t_max();
    t_hold();
    t_branch(3, "R7 branch no fwd");
    do_reset(1'b1);
    t_fwd();
    t_gap(0, "R5 one filler fwd");
    t_branch(1, "R7 branch fwd");
    t_mode_latch();
    flush();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule